// File: doc/BRIEF.md
# SDRAM Command Controller

This block sits between a simple request port and a 64-Mbit single-data-rate SDRAM with four banks of 1M x 16. It powers the memory up, programs its mode word, and then serves one read or write request at a time. For each request it activates the addressed row, issues a single-beat column command with auto-precharge, and waits out the row-close timing. Between accesses it inserts the periodic auto-refresh commands the array needs.

Requests arrive on a valid/ready handshake. A request carries a flat address, 16-bit write data and a per-byte enable. Read data comes back on a one-cycle response strobe, in request order. The pad tristate is split into an input bus, an output bus and an output enable. All device timings are parameters counted in clock cycles, and so is the refresh interval. The defaults assume a 125 MHz clock and spread 4096 refreshes over 64 ms.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held and afterwards until T_POWERUP cycles have passed, the bus carries only NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), req_ready is low and sd_dq_oe is low.
- R2: Initialisation issues, in order, one precharge with A10=1, INIT_REFS (2) auto-refreshes and one mode-register write. req_ready never rises before the mode-register write.
- R3: The mode word is written with BA=0. Its bits are: A2:A0=000 for a burst of one, A3=0 for sequential order, A6:A4=CAS_LAT, A9=1 for single-beat writes, and all other bits 0.
- R4: A request address splits as bank=req_addr[21:20], row=req_addr[19:8] and column=req_addr[7:0]. The activate carries bank and row. The following read or write carries the same bank, the column on A7:A0, and A10=1 so that the row closes by itself.
- R5: Every command uses the {cs_n,ras_n,cas_n,we_n} code NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001 or MODE=0000. No other pattern appears.
- R6: Commands keep these spacings. Activate to column command: at least T_RCD. Column command to the next activate or refresh: at least T_WR+T_RP. Activate to the next activate or refresh: at least T_RAS+T_RP. Refresh to the next command: at least T_RFC. Precharge to the next command: at least T_RP. A bank is never activated while its row is open.
- R7: A write command drives req_wdata on sd_dq_out with sd_dq_oe high in the same cycle, and sd_dqm[i] = ~req_be[i] (bit 1 is the upper byte). sd_dq_oe is low on every other command.
- R8: Read data is sampled on the edge CAS_LAT cycles after the edge on which the device took READ. rsp_valid is high for exactly the following cycle, with that data, and responses come in request order.
- R9: After initialisation, two consecutive refreshes are never further apart than REF_INTERVAL plus one access and one refresh.
- R10: A due refresh has priority. Once the access in progress has closed, req_ready stays low and REFRESH is issued before any new activate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / mode address |
| sd_dqm | output | 2 | Byte masks, bit 1 = upper byte |
| sd_dq_out | output | 16 | Data to the pads |
| sd_dq_oe | output | 1 | Pad output enable |
| sd_dq_in | input | 16 | Data from the pads |

## Verification
The bench builds the controller with CAS_LAT=3, a 20-cycle power-up delay and a 60-cycle refresh interval, with T_RCD=3, T_RP=3, T_RFC=8, T_RAS=6 and T_WR=2. The short power-up delay makes the whole initialisation sequence visible in a few dozen cycles. The short refresh interval makes refreshes fall due many times in the middle of back-to-back traffic, so refresh priority and the refresh spacing bound are exercised, not just reached once. The longest CAS latency puts the widest gap between command and capture under test, and a timing model in the bench checks every command spacing against the parameters.

// File: rtl/sdr_pkg.sv
// Shared definitions for the SDRAM command controller.
// Assumes commands are encoded as {cs_n, ras_n, cas_n, we_n}.
package sdr_pkg;

    typedef enum logic [3:0] {
        CMD_MODE  = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_NOP   = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_PREALL,
        ST_REF,
        ST_MODE,
        ST_IDLE,
        ST_COL
    } ctl_state_e;

    // Timer load giving at least t cycles between two commands
    // (the wait state plus the issuing state add two cycles).
    function automatic int unsigned gap_load(input int unsigned t);
        return (t > 2) ? t - 2 : 0;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
// Refresh interval timer: raises 'due' every INTERVAL cycles once enabled
// and clears it when the controller acknowledges the refresh.
// Assumes the controller serves a due refresh before the next expiry.
module sdr_refresh_timer #(
    parameter int INTERVAL = 1900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic due
);
    localparam int CNT_W = $clog2(INTERVAL + 1);

    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = enable && (cnt == '0);

    // Count down the interval and hold the request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(INTERVAL - 1);
            due <= 1'b0;
        end else if (enable) begin
            if (ack)
                due <= 1'b0;
            if (expire) begin
                cnt <= CNT_W'(INTERVAL - 1);
                due <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // A second expiry must never land on a refresh still waiting.
    assert_no_missed_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (!due || ack));

endmodule

// File: rtl/sdr_rd_capture.sv
// Read capture pipe: delays the READ marker by CAS_LAT cycles and samples
// the pad input on the edge where the device presents data.
// Assumes CAS_LAT >= 2 and single-beat reads.
module sdr_rd_capture #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [CAS_LAT-1:0] pipe;

    // Shift the READ marker along the latency pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= issue;
            for (int i = 1; i < CAS_LAT; i++)
                pipe[i] <= pipe[i-1];
        end
    end

    // Sample the pads and raise the strobe when the marker arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= pipe[CAS_LAT-1];
            if (pipe[CAS_LAT-1])
                rsp_data <= dq_in;
        end
    end

    // Every strobe follows a READ exactly CAS_LAT+1 cycles earlier.
    assert_rsp_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(issue, CAS_LAT + 1));

endmodule

// File: rtl/sdram_cmd_ctrl.sv
// SDRAM command controller: runs power-up initialisation, programs the mode
// word, serves one single-beat access at a time with row activate and an
// auto-precharged column command, and inserts periodic refreshes.
// Assumes ROW_W >= 11 (A10 is the precharge flag) and COL_W <= 10.
module sdram_cmd_ctrl
    import sdr_pkg::*;
#(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 12,
    parameter int COL_W        = 8,
    parameter int DATA_W       = 16,
    parameter int CAS_LAT      = 3,
    parameter int T_POWERUP    = 12500,
    parameter int T_RP         = 3,
    parameter int T_RCD        = 3,
    parameter int T_RFC        = 9,
    parameter int T_RAS        = 6,
    parameter int T_WR         = 2,
    parameter int T_MRD        = 2,
    parameter int REF_INTERVAL = 1900,
    parameter int INIT_REFS    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]               req_wdata,
    input  logic [DATA_W/8-1:0]             req_be,
    output logic                            rsp_valid,
    output logic [DATA_W-1:0]               rsp_rdata,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [ROW_W-1:0]                sd_addr,
    output logic [DATA_W/8-1:0]             sd_dqm,
    output logic [DATA_W-1:0]               sd_dq_out,
    output logic                            sd_dq_oe,
    input  logic [DATA_W-1:0]               sd_dq_in
);
    localparam int MASK_W    = DATA_W / 8;
    localparam int HOLD_OPEN = (T_RAS > T_RCD) ? T_RAS - T_RCD : 0;
    localparam int T_CLOSE   = ((HOLD_OPEN > T_WR) ? HOLD_OPEN : T_WR) + T_RP;
    localparam int TMR_W     = $clog2(T_POWERUP + T_RFC + T_CLOSE + T_RCD + T_MRD + 2);
    localparam int REFS_W    = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] AP_FLAG   = ROW_W'(1 << 10);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((1 << 9) | ((CAS_LAT % 8) << 4));

    ctl_state_e           st, nxt;
    logic [TMR_W-1:0]     tmr;
    logic [REFS_W-1:0]    refs_left;
    logic                 init_done;
    sdr_cmd_e             cmd_q;
    logic [BANK_W-1:0]    ba_q;
    logic [ROW_W-1:0]     addr_q;
    logic [MASK_W-1:0]    dqm_q;
    logic [DATA_W-1:0]    dq_q;
    logic                 oe_q;
    logic                 lat_write;
    logic [BANK_W-1:0]    lat_bank;
    logic [COL_W-1:0]     lat_col;
    logic [DATA_W-1:0]    lat_wdata;
    logic [MASK_W-1:0]    lat_be;
    logic                 ref_due;
    logic                 ref_ack;

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba     = ba_q;
    assign sd_addr   = addr_q;
    assign sd_dqm    = dqm_q;
    assign sd_dq_out = dq_q;
    assign sd_dq_oe  = oe_q;
    assign req_ready = (st == ST_IDLE) && !ref_due;
    assign ref_ack   = (st == ST_REF) && init_done;

    // Sequence initialisation, refreshes and accesses; register the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_WAIT;
            nxt       <= ST_PREALL;
            tmr       <= TMR_W'(gap_load(T_POWERUP));
            refs_left <= REFS_W'(INIT_REFS);
            init_done <= 1'b0;
            cmd_q     <= CMD_NOP;
            ba_q      <= '0;
            addr_q    <= '0;
            dqm_q     <= '0;
            dq_q      <= '0;
            oe_q      <= 1'b0;
            lat_write <= 1'b0;
            lat_bank  <= '0;
            lat_col   <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
        end else begin
            cmd_q <= CMD_NOP;
            oe_q  <= 1'b0;
            dqm_q <= '0;
            unique case (st)
                ST_WAIT: begin
                    if (tmr == '0) st <= nxt;
                    else           tmr <= tmr - 1'b1;
                end
                ST_PREALL: begin
                    cmd_q  <= CMD_PRE;
                    addr_q <= AP_FLAG;
                    st     <= ST_WAIT;
                    nxt    <= ST_REF;
                    tmr    <= TMR_W'(gap_load(T_RP));
                end
                ST_REF: begin
                    cmd_q <= CMD_REF;
                    st    <= ST_WAIT;
                    tmr   <= TMR_W'(gap_load(T_RFC));
                    if (!init_done) begin
                        refs_left <= refs_left - 1'b1;
                        nxt       <= (refs_left <= REFS_W'(1)) ? ST_MODE : ST_REF;
                    end else begin
                        nxt <= ST_IDLE;
                    end
                end
                ST_MODE: begin
                    cmd_q     <= CMD_MODE;
                    ba_q      <= '0;
                    addr_q    <= MODE_WORD;
                    init_done <= 1'b1;
                    st        <= ST_WAIT;
                    nxt       <= ST_IDLE;
                    tmr       <= TMR_W'(gap_load(T_MRD));
                end
                ST_IDLE: begin
                    if (ref_due) begin
                        st <= ST_REF;
                    end else if (req_valid) begin
                        cmd_q     <= CMD_ACT;
                        ba_q      <= req_addr[COL_W+ROW_W +: BANK_W];
                        addr_q    <= req_addr[COL_W +: ROW_W];
                        lat_write <= req_write;
                        lat_bank  <= req_addr[COL_W+ROW_W +: BANK_W];
                        lat_col   <= req_addr[COL_W-1:0];
                        lat_wdata <= req_wdata;
                        lat_be    <= req_be;
                        st        <= ST_WAIT;
                        nxt       <= ST_COL;
                        tmr       <= TMR_W'(gap_load(T_RCD));
                    end
                end
                ST_COL: begin
                    cmd_q  <= lat_write ? CMD_WRITE : CMD_READ;
                    ba_q   <= lat_bank;
                    addr_q <= ROW_W'(lat_col) | AP_FLAG;
                    if (lat_write) begin
                        oe_q  <= 1'b1;
                        dq_q  <= lat_wdata;
                        dqm_q <= ~lat_be;
                    end
                    st  <= ST_WAIT;
                    nxt <= ST_IDLE;
                    tmr <= TMR_W'(gap_load(T_CLOSE));
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    sdr_refresh_timer #(
        .INTERVAL(REF_INTERVAL)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (init_done),
        .ack    (ref_ack),
        .due    (ref_due)
    );

    sdr_rd_capture #(
        .CAS_LAT(CAS_LAT),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (cmd_q == CMD_READ),
        .dq_in     (sd_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );

    // A due refresh seen while idle reaches the bus two edges later.
    assert_refresh_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ref_due && init_done) |-> ##2 (cmd_q == CMD_REF));

    // The pads are driven only together with a write command.
    assert_oe_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd_q == CMD_WRITE));

    // No request is taken before the mode word is written.
    assert_ready_after_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);

    // An activate is always followed by at least one idle cycle.
    assert_act_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));

endmodule

// File: tb/tb_sdram_cmd_ctrl.sv
module tb_sdram_cmd_ctrl;
    localparam int CL = 3, T_PU = 20, T_RP = 3, T_RCD = 3, T_RFC = 8;
    localparam int T_RAS = 6, T_WR = 2, REFI = 60;
    localparam int REF_BOUND = REFI + T_RCD + T_RAS + T_WR + T_RP + T_RFC + 8;
    localparam logic [11:0] MODE_EXP = 12'h200 | 12'(CL << 4);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba, sd_dqm;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_out, sd_dq_in;

    always #4 clk = ~clk;

    sdram_cmd_ctrl #(
        .CAS_LAT(CL), .T_POWERUP(T_PU), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
        .T_RAS(T_RAS), .T_WR(T_WR), .REF_INTERVAL(REFI)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Background content of never-written locations.
    function automatic logic [15:0] bg(input int key);
        return 16'(key * 40503) ^ 16'h5A3C;
    endfunction

    logic [15:0] shadow[int];
    logic [15:0] mem[int];
    logic [15:0] exp_q[$];
    int          rd_cyc_q[$];

    int cyc = 0, init_step = 0, init_cyc = 0, n_ref_run = 0;
    int last_pre = -1000, last_ref = -1000, last_col = -1000, last_act_any = -1000;
    int last_act[4];
    int open_row[4];
    bit bank_open[4];
    bit seen_cmd = 0, rd_pend = 0;
    int rd_due = 0;
    logic [15:0] rd_val;

    // Device model: decodes the bus after each edge, checks timing, answers reads.
    always @(negedge clk) begin : model
        logic [3:0] c;
        int key;
        int b;
        if (!rst_n) begin
            sd_dq_in = 16'hDEAD;
            cyc = 0;
        end else begin
            cyc++;
            if (rd_pend && cyc == rd_due) begin
                sd_dq_in = rd_val;
                rd_pend = 0;
            end else begin
                sd_dq_in = 16'hDEAD ^ 16'(cyc);
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "unexpected response", rsp_rdata, 0);
                end else begin
                    chk(rsp_rdata == exp_q[0], "R8", "read data", rsp_rdata, exp_q[0]);
                    chk(cyc - rd_cyc_q[0] == CL + 1, "R8", "read latency", cyc - rd_cyc_q[0], CL + 1);
                    void'(exp_q.pop_front());
                    void'(rd_cyc_q.pop_front());
                end
            end
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            b = int'(sd_ba);
            if (!sd_cs_n && c != 4'b0111) begin
                chk(c inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101},
                    "R5", "command code", c, 4'b0111);
                if (!seen_cmd) begin
                    seen_cmd = 1;
                    chk(cyc >= T_PU, "R1", "first command cycle", cyc, T_PU);
                end
                if (c != 4'b0100)
                    chk(!sd_dq_oe, "R7", "oe on non-write", sd_dq_oe, 0);
                case (c)
                    4'b0010: begin
                        chk(init_step == 0 && sd_addr[10], "R2", "precharge-all step", init_step, 0);
                        init_step = 1;
                        last_pre = cyc;
                    end
                    4'b0001: begin
                        chk(cyc - last_pre >= T_RP, "R6", "precharge to refresh", cyc - last_pre, T_RP);
                        chk(cyc - last_ref >= T_RFC, "R6", "refresh to refresh", cyc - last_ref, T_RFC);
                        chk(cyc - last_col >= T_WR + T_RP, "R6", "column to refresh", cyc - last_col, T_WR + T_RP);
                        chk(cyc - last_act_any >= T_RAS + T_RP, "R6", "activate to refresh", cyc - last_act_any, T_RAS + T_RP);
                        if (init_step == 1 || init_step == 2) begin
                            init_step++;
                        end else begin
                            chk(init_step == 4, "R2", "refresh step", init_step, 4);
                            // R9 and R10: a refresh must not be starved by continuous requests.
                            if (n_ref_run > 0)
                                chk(cyc - last_ref <= REF_BOUND, "R9", "refresh spacing", cyc - last_ref, REF_BOUND);
                            n_ref_run++;
                        end
                        last_ref = cyc;
                    end
                    4'b0000: begin
                        chk(init_step == 3, "R2", "mode write step", init_step, 3);
                        chk(sd_addr == MODE_EXP, "R3", "mode word", sd_addr, MODE_EXP);
                        chk(sd_ba == 2'b00, "R3", "mode bank", sd_ba, 0);
                        chk(cyc - last_ref >= T_RFC, "R6", "refresh to mode", cyc - last_ref, T_RFC);
                        init_step = 4;
                        init_cyc = cyc;
                    end
                    4'b0011: begin
                        chk(init_step == 4, "R2", "activate before init", init_step, 4);
                        chk(!bank_open[b], "R6", "activate open bank", b, 0);
                        chk(cyc - last_ref >= T_RFC, "R6", "refresh to activate", cyc - last_ref, T_RFC);
                        chk(cyc - last_col >= T_WR + T_RP, "R6", "column to activate", cyc - last_col, T_WR + T_RP);
                        chk(cyc - last_act_any >= T_RAS + T_RP, "R6", "activate to activate", cyc - last_act_any, T_RAS + T_RP);
                        bank_open[b] = 1;
                        open_row[b] = int'(sd_addr);
                        last_act[b] = cyc;
                        last_act_any = cyc;
                    end
                    default: begin
                        chk(bank_open[b], "R6", "column on closed bank", b, 1);
                        chk(cyc - last_act[b] >= T_RCD, "R6", "activate to column", cyc - last_act[b], T_RCD);
                        chk(sd_addr[10], "R4", "auto-precharge flag", sd_addr[10], 1);
                        key = int'({sd_ba, 12'(open_row[b]), sd_addr[7:0]});
                        if (c == 4'b0100) begin
                            logic [15:0] cur;
                            chk(sd_dq_oe, "R7", "oe on write", sd_dq_oe, 1);
                            cur = mem.exists(key) ? mem[key] : bg(key);
                            if (!sd_dqm[0]) cur[7:0]  = sd_dq_out[7:0];
                            if (!sd_dqm[1]) cur[15:8] = sd_dq_out[15:8];
                            mem[key] = cur;
                        end else begin
                            rd_val = mem.exists(key) ? mem[key] : bg(key);
                            rd_pend = 1;
                            rd_due = cyc + CL;
                            rd_cyc_q.push_back(cyc);
                        end
                        bank_open[b] = 0;
                        last_col = cyc;
                    end
                endcase
            end
        end
    end

    // Issue one request and update the expected contents when it is taken.
    task automatic do_req(input bit w, input logic [21:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] cur;
        int key;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        while (!req_ready) @(negedge clk);
        key = int'(a);
        cur = shadow.exists(key) ? shadow[key] : bg(key);
        if (w) begin
            if (be[0]) cur[7:0]  = d[7:0];
            if (be[1]) cur[15:8] = d[15:8];
            shadow[key] = cur;
        end else begin
            exp_q.push_back(cur);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] row;
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        // R1: idle bus and no acceptance while reset is held.
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(!req_ready, "R1", "ready in reset", req_ready, 0);
        chk(!sd_dq_oe, "R1", "oe in reset", sd_dq_oe, 0);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk(init_step == 4, "R2", "init complete at ready", init_step, 4);

        // Directed corners: full, partial and empty byte masks; extreme address.
        do_req(1, 22'h000000, 16'h1234, 2'b11);
        do_req(0, 22'h000000, 16'h0000, 2'b00);
        do_req(1, 22'h3FFFFF, 16'hABCD, 2'b01);
        do_req(0, 22'h3FFFFF, 16'h0000, 2'b00);
        do_req(1, 22'h3FFFFF, 16'h5600, 2'b10);
        do_req(0, 22'h3FFFFF, 16'h0000, 2'b00);
        do_req(1, 22'h3FFFFF, 16'hFFFF, 2'b00);
        do_req(0, 22'h3FFFFF, 16'h0000, 2'b00);
        do_req(0, 22'h1ABC12, 16'h0000, 2'b00);
        do_req(0, 22'h2ABC12, 16'h0000, 2'b00);

        // Random traffic, mostly back to back so refreshes collide with requests.
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 4)
                0:       row = 12'h000;
                1:       row = 12'h001;
                2:       row = 12'hFFF;
                default: row = 12'($urandom % 4096);
            endcase
            do_req(1'($urandom % 2), {2'($urandom % 4), row, 8'($urandom % 32)},
                   16'($urandom), 2'($urandom % 4));
            if ($urandom % 10 == 0)
                repeat ($urandom % 80) @(negedge clk);
        end

        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "responses outstanding", exp_q.size(), 0);
        // R9 and R10: enough refreshes over the run despite constant traffic.
        chk(n_ref_run >= (cyc - init_cyc) / REF_BOUND, "R9", "refresh count",
            n_ref_run, (cyc - init_cyc) / REF_BOUND);
        summary();
        $finish;
    end

endmodule